// File: doc/BRIEF.md
# Multichannel Programmable-Rate Sigma-Delta Decimator

This block turns the single-bit streams of several sigma-delta modulators, all clocked together, into signed 16-bit PCM words. Each channel runs its own third-order cascaded integrator-comb (CIC) filter. Every channel shares one decimation phase counter, so all output words change on the same clock edge. One strobe marks that edge for all of them.

The system clock is first divided by a programmable master divider to give the internal clock. A further division by 8 of the internal clock gives the modulator tick, and one bit per channel is taken on each tick. A two-bit rate field picks one of four decimation ratios, each twice the one before it. The filter output is shifted right by an amount that depends on the ratio, so that a full-scale input lands on the signed 16-bit range.

The rate field may change while the block runs. The change waits for the end of the current decimation window. At that point the filter state is cleared, and the strobe stays low until the new window history is complete.

Top module: `sd_decimator`

## Requirements
- R1: While reset is asserted, and after any reset, every PCM word reads 0 and the valid strobe is low.
- R2: The internal clock enable fires once every `mclk_div`+1 system clock cycles. One modulator bit per channel is taken on every 8th internal enable. In steady state, successive valid strobes are therefore R*8*(`mclk_div`+1) system cycles apart, where R is the decimation ratio.
- R3: The rate field selects the decimation ratio as follows: 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256 modulator bits per output word.
- R4: A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. An all-ones stream saturates to 32767 and an all-zeros stream gives -32768, at every ratio.
- R5: The response is third-order sinc, scaled by R^3 and then shifted right by 3*log2(R)-15. Patterns repeating every 4 bits with one, two or three ones therefore give exactly -16384, 0 and +16384.
- R6: Every channel filters its own bit stream. All channels load their new words on the same single strobe cycle.
- R7: After reset the first two decimated results are discarded. The first word flagged valid is already the exact steady-state value of the input pattern.
- R8: A new rate value takes effect only at the end of the current window. At that point the integrators and comb delays are cleared and the sample phase restarts. The next two results are discarded, and the first valid word under the new ratio is exact and at least 3 new-ratio periods after the request.
- R9: Between strobes, the PCM words hold their last value.
- R10: The valid strobe is high for exactly one system clock cycle per output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mclk_div | input | DIV_W (2) | Master divider setting; the internal clock enable fires every mclk_div+1 cycles |
| rate_sel | input | RATE_W (2) | Output-rate select: 0 gives ratio 32, 1 gives 64, 2 gives 128, 3 gives 256 |
| mod_bits | input | N_CH (6) | One modulator bit per channel, sampled on each modulator tick |
| pcm_data | output | N_CH*OUT_W (96) | Signed PCM words; channel c occupies bits [c*16 +: 16] |
| pcm_valid | output | 1 | One-cycle strobe marking new words on all channels |

## Verification
The bench goes after the scale extremes. A design that wrapped instead of saturating would return -32768 for an all-ones stream at any ratio, and one with the wrong per-ratio shift would give quarter-duty results off by powers of two. It also checks the first valid word after reset and after a rate change against the exact steady value. A design that did not clear the comb delays, or that counted too few discarded results, would report a partly filled window. Strobe spacing is measured under several divider settings and ratios, which exposes an off-by-one in either counter. Per-channel patterns that differ across all six channels catch a crossed channel index or a lane that was not loaded.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  // default geometry of the decimator
  localparam int SDD_N_CH      = 6;
  localparam int SDD_OUT_W     = 16;
  localparam int SDD_DIV_W     = 2;
  localparam int SDD_RATE_W    = 2;
  localparam int SDD_LOG2_RMIN = 5;
  localparam int SDD_MOD_OSR   = 8;
  localparam int SDD_SETTLE    = 2;
  localparam int SDD_ORDER     = 3;

  // accumulator width for a given largest log2 ratio: order*log2(R) of growth,
  // one sign bit, and one more so that +R^3 is representable
  function automatic int sdd_acc_w(input int log2_rmax);
    return SDD_ORDER * log2_rmax + 2;
  endfunction
endpackage

// File: rtl/sdd_tick_gen.sv
module sdd_tick_gen #(
  parameter int DIV_W = 2,
  parameter int SUB   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_set,
  output logic             mod_tick
);
  localparam int SUB_W = $clog2(SUB);

  logic [DIV_W-1:0] div_cnt, div_nx;
  logic [SUB_W-1:0] sub_cnt, sub_nx;
  logic             int_en;

  always_comb begin
    int_en   = (div_cnt >= div_set);
    div_nx   = int_en ? '0 : div_cnt + 1'b1;
    sub_nx   = sub_cnt;
    if (int_en) begin
      sub_nx = (sub_cnt == SUB_W'(SUB - 1)) ? '0 : sub_cnt + 1'b1;
    end
    mod_tick = int_en && (sub_cnt == SUB_W'(SUB - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sub_cnt <= '0;
    end else begin
      div_cnt <= div_nx;
      sub_cnt <= sub_nx;
    end
  end

  // R2: modulator ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_tick |=> !mod_tick);
endmodule

// File: rtl/sdd_ctrl.sv
module sdd_ctrl #(
  parameter int RATE_W    = 2,
  parameter int LOG2_RMIN = 5,
  parameter int OUT_W     = 16,
  parameter int SETTLE    = 2,
  parameter int ORDER     = 3,
  parameter int SH_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              dump,
  output logic              flush,
  output logic              load,
  output logic [SH_W-1:0]   shift,
  output logic              valid
);
  localparam int N_RATES = 1 << RATE_W;
  localparam int PH_W    = LOG2_RMIN + N_RATES - 1;
  localparam int ST_W    = $clog2(SETTLE + 1);

  logic [PH_W-1:0]   phase, phase_nx;
  logic [RATE_W-1:0] rate_q, rate_nx;
  logic [ST_W-1:0]   settle, settle_nx;
  logic              valid_nx;
  logic [PH_W:0]     rlen;
  logic              last, change;

  always_comb begin
    rlen   = {{PH_W{1'b0}}, 1'b1} << (LOG2_RMIN + int'(rate_q));
    last   = tick && ({1'b0, phase} == rlen - 1'b1);
    change = (rate_sel != rate_q);
    flush  = last && change;
    dump   = last && !change;
    load   = dump && (settle == ST_W'(SETTLE));
    shift  = SH_W'(ORDER * (LOG2_RMIN + int'(rate_q)) - (OUT_W - 1));

    phase_nx = phase;
    if (tick) begin
      phase_nx = last ? '0 : phase + 1'b1;
    end
    rate_nx   = flush ? rate_sel : rate_q;
    settle_nx = settle;
    if (flush) begin
      settle_nx = '0;
    end else if (dump && (settle != ST_W'(SETTLE))) begin
      settle_nx = settle + 1'b1;
    end
    valid_nx = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      rate_q <= '0;
      settle <= '0;
      valid  <= 1'b0;
    end else begin
      phase  <= phase_nx;
      rate_q <= rate_nx;
      settle <= settle_nx;
      valid  <= valid_nx;
    end
  end

  // R3: the phase counter stays inside the window of the active ratio
  p_phase_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, phase} < rlen));

  // R8: the active ratio changes only on a flush boundary
  p_rate_moves_on_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q != $past(rate_q)) |-> $past(flush));

  // R8: a flush is never followed by an immediate load
  p_flush_then_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid);
endmodule

// File: rtl/sdd_cic_chan.sv
module sdd_cic_chan #(
  parameter int ACC_W = 26,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    dump,
  input  logic                    flush,
  input  logic                    load,
  input  logic                    bit_in,
  input  logic [SH_W-1:0]         shift,
  output logic signed [OUT_W-1:0] pcm
);
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  logic signed [ACC_W-1:0] i1, i2, i3, d1, d2, d3;
  logic signed [ACC_W-1:0] i1_n, i2_n, i3_n, c1, c2, c3, x, scaled, full;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    x      = bit_in ? ACC_W'(1) : '1;
    i1_n   = i1 + x;
    i2_n   = i2 + i1_n;
    i3_n   = i3 + i2_n;
    c1     = i3_n - d1;
    c2     = c1 - d2;
    c3     = c2 - d3;
    scaled = c3 >>> shift;
    if (scaled > POS_LIM) begin
      sat = POS_LIM[OUT_W-1:0];
    end else if (scaled < NEG_LIM) begin
      sat = NEG_LIM[OUT_W-1:0];
    end else begin
      sat = scaled[OUT_W-1:0];
    end
    full = ACC_W'(1) << (int'(shift) + OUT_W - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i1  <= '0;
      i2  <= '0;
      i3  <= '0;
      d1  <= '0;
      d2  <= '0;
      d3  <= '0;
      pcm <= '0;
    end else begin
      if (tick) begin
        if (flush) begin
          i1 <= '0;
          i2 <= '0;
          i3 <= '0;
          d1 <= '0;
          d2 <= '0;
          d3 <= '0;
        end else begin
          i1 <= i1_n;
          i2 <= i2_n;
          i3 <= i3_n;
          if (dump) begin
            d1 <= i3_n;
            d2 <= c1;
            d3 <= c2;
          end
        end
      end
      if (load) begin
        pcm <= sat;
      end
    end
  end

  // R5: a settled comb result never exceeds the R^3 full-scale bound
  p_settled_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((c3 <= full) && (c3 >= -full)));

  // R9: the word holds whenever no load occurred
  p_pcm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pcm));
endmodule

// File: rtl/sd_decimator.sv
module sd_decimator
  import sdd_pkg::*;
#(
  parameter int N_CH      = SDD_N_CH,
  parameter int OUT_W     = SDD_OUT_W,
  parameter int DIV_W     = SDD_DIV_W,
  parameter int RATE_W    = SDD_RATE_W,
  parameter int LOG2_RMIN = SDD_LOG2_RMIN,
  parameter int MOD_OSR   = SDD_MOD_OSR,
  parameter int SETTLE    = SDD_SETTLE
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        mclk_div,
  input  logic [RATE_W-1:0]       rate_sel,
  input  logic [N_CH-1:0]         mod_bits,
  output logic [N_CH*OUT_W-1:0]   pcm_data,
  output logic                    pcm_valid
);
  localparam int N_RATES   = 1 << RATE_W;
  localparam int LOG2_RMAX = LOG2_RMIN + N_RATES - 1;
  localparam int ACC_W     = sdd_acc_w(LOG2_RMAX);
  localparam int SH_W      = $clog2(SDD_ORDER * LOG2_RMAX + 1);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            tick, dump, flush, load;
  logic [SH_W-1:0] shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  sdd_tick_gen #(.DIV_W(DIV_W), .SUB(MOD_OSR)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .div_set(mclk_div), .mod_tick(tick)
  );

  sdd_ctrl #(
    .RATE_W(RATE_W), .LOG2_RMIN(LOG2_RMIN), .OUT_W(OUT_W),
    .SETTLE(SETTLE), .ORDER(SDD_ORDER), .SH_W(SH_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .rate_sel(rate_sel),
    .dump(dump), .flush(flush), .load(load), .shift(shift), .valid(pcm_valid)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    sdd_cic_chan #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_cic (
      .clk(clk), .rst_n(rst_sync_n), .tick(tick), .dump(dump), .flush(flush),
      .load(load), .bit_in(mod_bits[c]), .shift(shift),
      .pcm(pcm_data[c*OUT_W +: OUT_W])
    );
  end

  // R10: the strobe lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pcm_valid |=> !pcm_valid);
endmodule

// File: tb/sd_decimator_tb.sv
module sd_decimator_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N_CH = 6;
  localparam int OUT_W = 16;

  logic                  clk;
  logic                  rst_n;
  logic [1:0]            mclk_div;
  logic [1:0]            rate_sel;
  logic [N_CH-1:0]       mod_bits;
  logic [N_CH*OUT_W-1:0] pcm_data;
  logic                  pcm_valid;

  int n_checks = 0;
  int n_bad    = 0;
  int cyc      = 0;
  int vcount   = 0;
  int last_vt  = 0;
  int last_int = 0;
  int pat_idx  = 0;
  logic [2:0] codes [N_CH];

  sd_decimator u_dut (
    .clk(clk), .rst_n(rst_n), .mclk_div(mclk_div), .rate_sel(rate_sel),
    .mod_bits(mod_bits), .pcm_data(pcm_data), .pcm_valid(pcm_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: [23:22] rate, [21:20] divider, [17:0] six 3-bit pattern codes (ch0 lowest)
  localparam logic [23:0] VECS [8] = '{
    {2'd0, 2'd0, 2'd0, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd4},
    {2'd1, 2'd0, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0},
    {2'd2, 2'd0, 2'd0, 3'd3, 3'd3, 3'd1, 3'd1, 3'd4, 3'd2},
    {2'd3, 2'd0, 2'd0, 3'd4, 3'd0, 3'd4, 3'd0, 3'd3, 3'd1},
    {2'd0, 2'd1, 2'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd1},
    {2'd1, 2'd2, 2'd0, 3'd2, 3'd4, 3'd0, 3'd3, 3'd1, 3'd2},
    {2'd2, 2'd1, 2'd0, 3'd0, 3'd0, 3'd4, 3'd4, 3'd2, 3'd3},
    {2'd0, 2'd3, 2'd0, 3'd3, 3'd1, 3'd0, 3'd2, 3'd4, 3'd3}
  };

  function automatic int exp_of(input logic [2:0] code);
    case (code)
      3'd0:    return -32768;
      3'd1:    return -16384;
      3'd2:    return 0;
      3'd3:    return 16384;
      default: return 32767;
    endcase
  endfunction

  function automatic logic pat_bit(input logic [2:0] code, input int idx);
    case (code)
      3'd0:    return 1'b0;
      3'd1:    return (idx % 4) == 0;
      3'd2:    return (idx % 2) == 1;
      3'd3:    return (idx % 4) != 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int chan_val(input int c);
    logic signed [OUT_W-1:0] w;
    w = pcm_data[c*OUT_W +: OUT_W];
    return int'(w);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // modulator stream: each bit held for one modulator period, changed at negedge
  initial begin
    int hold = 0;
    mod_bits = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        hold = 0;
        pat_idx = 0;
      end else begin
        hold++;
        if (hold >= 8 * (int'(mclk_div) + 1)) begin
          hold = 0;
          pat_idx++;
        end
      end
      for (int c = 0; c < N_CH; c++) mod_bits[c] = pat_bit(codes[c], pat_idx);
    end
  end

  // strobe monitor, sampled at negedge
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pcm_valid) begin
        if (prev) chk(1'b0, "R10 strobe wider than one cycle", 1, 0);
        vcount++;
        last_int = cyc - last_vt;
        last_vt  = cyc;
      end
      prev = pcm_valid;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_valids(input int n);
    int target = vcount + n;
    while (vcount < target) step();
  endtask

  task automatic set_vec(input logic [23:0] v);
    rate_sel = v[23:22];
    mclk_div = v[21:20];
    for (int c = 0; c < N_CH; c++) codes[c] = v[c*3 +: 3];
  endtask

  task automatic check_words(input string ctx);
    logic all_ok = 1'b1;
    for (int c = 0; c < N_CH; c++) begin
      int e = exp_of(codes[c]);
      if (chan_val(c) != e) all_ok = 1'b0;
      if (codes[c] == 3'd0 || codes[c] == 3'd4)
        chk(chan_val(c) == e, {"R4 extreme ", ctx}, chan_val(c), e);
      else
        chk(chan_val(c) == e, {"R5 duty ", ctx}, chan_val(c), e);
    end
    chk(all_ok, {"R6 all lanes on one strobe ", ctx}, int'(all_ok), 1);
  endtask

  task automatic run_main();
    int t_rel, t_chg, per, snap;
    rst_n = 1'b0;
    set_vec(VECS[0]);
    repeat (5) step();
    chk(pcm_data == '0, "R1 words zero in reset", int'(pcm_data[15:0]), 0);
    chk(pcm_valid == 1'b0, "R1 strobe low in reset", int'(pcm_valid), 0);
    rst_n = 1'b1;
    t_rel = cyc;
    wait_valids(1);
    chk((cyc - t_rel) >= 3 * 256, "R7 two results discarded after reset", cyc - t_rel, 3 * 256);
    check_words("R7 first valid after reset");

    // table walk
    for (int k = 0; k < 8; k++) begin
      set_vec(VECS[k]);
      wait_valids(4);
      per = (32 << int'(rate_sel)) * 8 * (int'(mclk_div) + 1);
      check_words($sformatf("vector %0d", k));
      chk(last_int == per, "R2 R3 strobe spacing", last_int, per);
    end

    // R9: words hold between strobes while bits keep streaming
    snap = chan_val(2);
    repeat (100) step();
    chk(chan_val(2) == snap, "R9 word held between strobes", chan_val(2), snap);

    // R8: rate change with new patterns; first valid must be exact
    set_vec({2'd0, 2'd0, 2'd0, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd4});
    wait_valids(4);
    set_vec({2'd2, 2'd0, 2'd0, 3'd1, 3'd4, 3'd3, 3'd0, 3'd2, 3'd3});
    t_chg = cyc;
    wait_valids(1);
    chk((cyc - t_chg) >= 3 * 1024, "R8 discards after rate change", cyc - t_chg, 3 * 1024);
    check_words("R8 first valid after rate change");
    wait_valids(1);
    chk(last_int == 1024, "R8 new ratio spacing", last_int, 1024);
    check_words("R8 second valid after rate change");

    // R3 highest ratio down to lowest
    set_vec({2'd3, 2'd0, 2'd0, 3'd2, 3'd2, 3'd1, 3'd3, 3'd4, 3'd0});
    wait_valids(2);
    chk(last_int == 2048, "R3 ratio 256 spacing", last_int, 2048);
    check_words("R3 ratio 256");

    // R1: reset in mid-run clears the outputs
    rst_n = 1'b0;
    repeat (2) step();
    chk(pcm_data == '0, "R1 words cleared by mid-run reset", int'(pcm_data[15:0]), 0);
    chk(pcm_valid == 1'b0, "R1 strobe low after mid-run reset", int'(pcm_valid), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    mclk_div = '0;
    rate_sel = '0;
    rst_n    = 1'b0;
    for (int c = 0; c < N_CH; c++) codes[c] = 3'd0;
    fork
      run_main();
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 190000);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule